// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Sequencer

This block is the master side of an open-drain single-wire bus, at the level of single bit operations. A client issues one request at a time on a small command interface. The request is a bus reset with presence detection, a write of one bit, or a read of one bit. The sequencer drives the line low through a registered pull-down enable and releases it at the correct time. It samples the synchronised line level at a fixed point and returns the result with a one-clock done strobe.

All durations are whole microseconds, counted from a microsecond tick that the block derives from the system clock. The divider restarts at each accepted request, so every phase lasts an exact number of clock cycles. There are two reset-specific corrections. The reset low time is lengthened by an edge-compensation term for slow falling edges. The reset high window is derived from the slaves' worst-case presence timing, and can be raised to a floor that suits networks with several device families.

Top module: `swb_seq_top`

## Requirements
- R1: A reset request (opcode 2'b00) holds `line_pull_o` high for exactly (T_RSTL_US + T_FALL_US) microseconds, counted from the clock edge that accepts the request.
- R2: After the reset low phase, the line stays released for a high window. Its length is the larger of (T_PDH_MAX_US + T_PDL_MAX_US + T_REC_MIN_US) and, when MIXED_NET is 1, T_MIXED_MIN_US. `done_o` is raised at the end of that window.
- R3: During a reset, the line is sampled T_MSP_US microseconds after release. `result_o` is 1 (slave present) when that sample is low and 0 when it is high.
- R4: A write request (opcode 2'b01) pulls the line low for T_W0L_US microseconds when `cmd_bit_i` is 0 and for T_W1L_US microseconds when it is 1. `result_o` reads 0 with its done strobe.
- R5: A read request (opcode 2'b10) pulls the line low for T_RDL_US microseconds. It samples the line T_RDS_US microseconds after the falling edge and returns that level on `result_o`.
- R6: Every write or read slot lasts exactly T_SLOT_US microseconds from the falling edge to `done_o`. The line is released during the final part of the slot (recovery).
- R7: `done_o` is high for exactly one clock per accepted request, and `result_o` is valid in that cycle. `busy_o` is high from the cycle after acceptance until done.
- R8: A request presented while `busy_o` is high is ignored: the running operation keeps its timing and produces one done strobe.
- R9: Opcode 2'b11 is ignored: no pull-down, no busy and no done strobe follow it.
- R10: After reset, `line_pull_o`, `done_o` and `busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Request strobe, taken only while idle |
| cmd_op_i | input | 2 | 00 reset, 01 write bit, 10 read bit, 11 ignored |
| cmd_bit_i | input | 1 | Bit value for a write request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion strobe |
| result_o | output | 1 | Presence flag (reset) or read bit (read), valid with done |
| line_pull_o | output | 1 | Open-drain enable: 1 pulls the bus low |
| line_i | input | 1 | Sensed bus level |

## Verification
Resets are run in three slave patterns: no slave, a presence pulse that covers the sample point, and a presence pulse that begins only after the sample point. Together they separate a correct sample instant from early or late sampling and from an inverted presence flag. Writes of both values and reads against a slave holding the line low or leaving it high are swept in every order. This separates the two write low times and the read low time, and catches any swap of the read polarity or sample point. Requests injected mid-operation and the reserved opcode show that no stray request disturbs the pulse length or adds a done strobe.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } swb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_HIGH,
    ST_SLOT_LOW,
    ST_SLOT_REST
  } swb_state_e;

  function automatic int unsigned swb_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swb_us_tick.sv
module swb_us_tick #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  generate
    if (CLK_PER_US > 1) begin : g_gap
      // R6: ticks are spaced, never two in a row
      p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !clr_i) |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/swb_line_sync.sv
module swb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh_q[i] <= 1'b1;
        else if (i == 0) sh_q[i] <= line_i;
        else sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign line_o = sh_q[STAGES-1];

endmodule

// File: rtl/swb_phase_ctrl.sv
module swb_phase_ctrl
  import swb_pkg::*;
#(
  parameter int unsigned T_RSTL_US      = 480,
  parameter int unsigned T_FALL_US      = 0,
  parameter int unsigned T_PDH_MAX_US   = 60,
  parameter int unsigned T_PDL_MAX_US   = 240,
  parameter int unsigned T_REC_MIN_US   = 5,
  parameter bit          MIXED_NET      = 1'b1,
  parameter int unsigned T_MIXED_MIN_US = 480,
  parameter int unsigned T_MSP_US       = 70,
  parameter int unsigned T_W0L_US       = 60,
  parameter int unsigned T_W1L_US       = 6,
  parameter int unsigned T_RDL_US       = 6,
  parameter int unsigned T_RDS_US       = 15,
  parameter int unsigned T_SLOT_US      = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       line_s_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_bit_i,
  output logic       accept_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       result_o,
  output logic       pull_o
);
  localparam int unsigned RSTL_EFF = T_RSTL_US + T_FALL_US;
  localparam int unsigned RSTH_MIN = T_PDH_MAX_US + T_PDL_MAX_US + T_REC_MIN_US;
  localparam int unsigned RSTH_EFF = MIXED_NET ? swb_max(RSTH_MIN, T_MIXED_MIN_US) : RSTH_MIN;
  localparam int unsigned CNT_MAX  = swb_max(swb_max(RSTL_EFF, RSTH_EFF), T_SLOT_US);
  localparam int unsigned CW       = $clog2(CNT_MAX + 1);

  localparam logic [CW-1:0] C_RSTL = CW'(RSTL_EFF);
  localparam logic [CW-1:0] C_RSTH = CW'(RSTH_EFF);
  localparam logic [CW-1:0] C_MSP  = CW'(T_MSP_US);
  localparam logic [CW-1:0] C_W0L  = CW'(T_W0L_US);
  localparam logic [CW-1:0] C_W1L  = CW'(T_W1L_US);
  localparam logic [CW-1:0] C_RDL  = CW'(T_RDL_US);
  localparam logic [CW-1:0] C_RDS  = CW'(T_RDS_US);
  localparam logic [CW-1:0] C_SLOT = CW'(T_SLOT_US);

  swb_state_e    state_q;
  swb_op_e       op_q;
  logic          bit_q;
  logic [CW-1:0] us_q;
  logic [CW-1:0] us_nxt;
  logic [CW-1:0] low_len;
  logic          pull_q;
  logic          done_q;
  logic          res_q;

  assign us_nxt   = us_q + 1'b1;
  assign accept_o = (state_q == ST_IDLE) && cmd_valid_i && (swb_op_e'(cmd_op_i) != OP_NONE);

  always_comb begin
    if (op_q == OP_READ) low_len = C_RDL;
    else if (bit_q)      low_len = C_W1L;
    else                 low_len = C_W0L;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      bit_q   <= 1'b0;
      us_q    <= '0;
      pull_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            op_q    <= swb_op_e'(cmd_op_i);
            bit_q   <= cmd_bit_i;
            us_q    <= '0;
            pull_q  <= 1'b1;
            res_q   <= 1'b0;
            state_q <= (swb_op_e'(cmd_op_i) == OP_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
          end
        end
        ST_RST_LOW: begin
          if (tick_i) begin
            if (us_nxt == C_RSTL) begin
              pull_q  <= 1'b0;
              us_q    <= '0;
              state_q <= ST_RST_HIGH;
            end else begin
              us_q <= us_nxt;
            end
          end
        end
        ST_RST_HIGH: begin
          if (tick_i) begin
            us_q <= us_nxt;
            if (us_nxt == C_MSP) res_q <= ~line_s_i;
            if (us_nxt == C_RSTH) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SLOT_LOW, ST_SLOT_REST: begin
          if (tick_i) begin
            us_q <= us_nxt;
            if (op_q == OP_READ && us_nxt == C_RDS) res_q <= line_s_i;
            if (state_q == ST_SLOT_LOW && us_nxt == low_len) begin
              pull_q  <= 1'b0;
              state_q <= ST_SLOT_REST;
            end
            if (us_nxt == C_SLOT) begin
              pull_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
  assign pull_o   = pull_q;

  // R7: done lasts a single clock
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: line released whenever idle
  p_idle_released_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !pull_q);

  // R6: counter never passes the slot length inside a slot
  p_slot_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLOT_LOW || state_q == ST_SLOT_REST) |-> (us_q < C_SLOT));

endmodule

// File: rtl/swb_seq_top.sv
module swb_seq_top #(
  parameter int unsigned CLK_PER_US     = 50,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned T_RSTL_US      = 480,
  parameter int unsigned T_FALL_US      = 0,
  parameter int unsigned T_PDH_MAX_US   = 60,
  parameter int unsigned T_PDL_MAX_US   = 240,
  parameter int unsigned T_REC_MIN_US   = 5,
  parameter bit          MIXED_NET      = 1'b1,
  parameter int unsigned T_MIXED_MIN_US = 480,
  parameter int unsigned T_MSP_US       = 70,
  parameter int unsigned T_W0L_US       = 60,
  parameter int unsigned T_W1L_US       = 6,
  parameter int unsigned T_RDL_US       = 6,
  parameter int unsigned T_RDS_US       = 15,
  parameter int unsigned T_SLOT_US      = 70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       cmd_bit_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       result_o,
  output logic       line_pull_o,
  input  logic       line_i
);
  logic tick;
  logic accept;
  logic line_s;

  swb_us_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
    .clk(clk), .rst(rst), .clr_i(accept), .tick_o(tick)
  );

  swb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .line_i(line_i), .line_o(line_s)
  );

  swb_phase_ctrl #(
    .T_RSTL_US(T_RSTL_US), .T_FALL_US(T_FALL_US),
    .T_PDH_MAX_US(T_PDH_MAX_US), .T_PDL_MAX_US(T_PDL_MAX_US),
    .T_REC_MIN_US(T_REC_MIN_US), .MIXED_NET(MIXED_NET),
    .T_MIXED_MIN_US(T_MIXED_MIN_US), .T_MSP_US(T_MSP_US),
    .T_W0L_US(T_W0L_US), .T_W1L_US(T_W1L_US),
    .T_RDL_US(T_RDL_US), .T_RDS_US(T_RDS_US), .T_SLOT_US(T_SLOT_US)
  ) ctrl_i (
    .clk(clk), .rst(rst), .tick_i(tick), .line_s_i(line_s),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_bit_i(cmd_bit_i),
    .accept_o(accept), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .pull_o(line_pull_o)
  );

  // R8: a pull-down only starts after a request seen while idle
  p_start_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pull_o) |-> $past(cmd_valid_i && !busy_o));

  // R9: the reserved opcode never starts an operation
  p_reserved_op_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && cmd_valid_i && cmd_op_i == 2'b11) |=> !busy_o);

  // R6: line already released when done is reported
  p_released_at_done_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !line_pull_o);

endmodule

// File: tb/swb_seq_top_tb.sv
module swb_seq_top_tb_top;
  localparam int CPU   = 4;
  localparam int RSTL  = 40;
  localparam int FALL  = 4;
  localparam int PDH   = 6;
  localparam int PDL   = 24;
  localparam int RECM  = 2;
  localparam int MIXM  = 48;
  localparam int MSP   = 7;
  localparam int W0L   = 6;
  localparam int W1L   = 1;
  localparam int RDL   = 1;
  localparam int RDS   = 2;
  localparam int SLOT  = 8;
  localparam int RLEFF = RSTL + FALL;
  localparam int RHSUM = PDH + PDL + RECM;
  localparam int RHEFF = (RHSUM > MIXM) ? RHSUM : MIXM;

  // slave modes
  localparam int SM_NONE = 0, SM_PRES = 1, SM_LATE = 2, SM_RD0 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_bit = 1'b0;
  logic busy, done, result, pull, bus_line;
  logic slave_pull;

  int cyc = 0;
  int acc = 0;
  int smode = SM_NONE;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    int s;
    s = cyc - acc;
    case (smode)
      SM_PRES: slave_pull = (s >= (RLEFF + PDH) * CPU) && (s < (RLEFF + PDH + PDL) * CPU);
      SM_LATE: slave_pull = (s >= (RLEFF + MSP + 2) * CPU) && (s < (RLEFF + MSP + 20) * CPU);
      SM_RD0:  slave_pull = (s >= 0) && (s < 5 * CPU);
      default: slave_pull = 1'b0;
    endcase
  end

  assign bus_line = ~(pull | slave_pull);

  swb_seq_top #(
    .CLK_PER_US(CPU), .T_RSTL_US(RSTL), .T_FALL_US(FALL),
    .T_PDH_MAX_US(PDH), .T_PDL_MAX_US(PDL), .T_REC_MIN_US(RECM),
    .MIXED_NET(1'b1), .T_MIXED_MIN_US(MIXM), .T_MSP_US(MSP),
    .T_W0L_US(W0L), .T_W1L_US(W1L), .T_RDL_US(RDL), .T_RDS_US(RDS),
    .T_SLOT_US(SLOT)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_bit_i(cmd_bit), .busy_o(busy), .done_o(done), .result_o(result),
    .line_pull_o(pull), .line_i(bus_line)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one request and measure; inject>0 pushes a reset request at that negedge
  task automatic run_cmd(input logic [1:0] op, input logic b, input int mode,
                         input int inject, input int exp_low, input int exp_idx,
                         input int exp_res, input string rl, input string rt);
    int lows, didx, dcnt, res;
    bit busy_seen;
    lows = 0; didx = -1; dcnt = 0; res = -1; busy_seen = 1'b0;
    @(negedge clk);
    smode = mode;
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    acc = cyc + 1;
    for (int idx = 1; idx <= exp_idx + 6; idx++) begin
      @(negedge clk);
      if (idx == 1) begin
        cmd_valid = 1'b0;
        busy_seen = busy;
      end
      if (inject > 0 && idx == inject) begin cmd_op = 2'b00; cmd_valid = 1'b1; end
      if (inject > 0 && idx == inject + 1) cmd_valid = 1'b0;
      if (pull) lows++;
      if (done) begin
        dcnt++;
        if (didx < 0) begin didx = idx; res = result; end
      end
    end
    smode = SM_NONE;
    check(lows == exp_low, rl, lows, exp_low);
    check(didx == exp_idx, rt, didx, exp_idx);
    check(dcnt == 1, "R7 done count", dcnt, 1);
    check(busy_seen, "R7 busy", busy_seen, 1);
    if (exp_res >= 0) check(res == exp_res, "R3/R5 result", res, exp_res);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!finished && wd < 150000) begin @(posedge clk); wd++; end
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R10 reset state
    @(negedge clk);
    check(pull == 1'b0 && done == 1'b0 && busy == 1'b0, "R10", {pull, done, busy}, 0);

    // R1, R2, R3 reset with three slave patterns
    run_cmd(2'b00, 1'b0, SM_NONE, 0, RLEFF*CPU, (RLEFF+RHEFF)*CPU+1, 0, "R1 low", "R2 window");
    run_cmd(2'b00, 1'b0, SM_PRES, 0, RLEFF*CPU, (RLEFF+RHEFF)*CPU+1, 1, "R1 low", "R2 window");
    run_cmd(2'b00, 1'b0, SM_LATE, 0, RLEFF*CPU, (RLEFF+RHEFF)*CPU+1, 0, "R1 low", "R2 window");

    // R4, R5, R6 sweep of all slot kinds in every ordering pair
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k < 2; k++) begin
          int v;
          v = (k == 0) ? a : c;
          case (v)
            0: run_cmd(2'b01, 1'b0, SM_NONE, 0, W0L*CPU, SLOT*CPU+1, 0, "R4 w0 low", "R6 slot");
            1: run_cmd(2'b01, 1'b1, SM_NONE, 0, W1L*CPU, SLOT*CPU+1, 0, "R4 w1 low", "R6 slot");
            2: run_cmd(2'b10, 1'b0, SM_RD0,  0, RDL*CPU, SLOT*CPU+1, 0, "R5 rd low", "R6 slot");
            default: run_cmd(2'b10, 1'b1, SM_NONE, 0, RDL*CPU, SLOT*CPU+1, 1, "R5 rd low", "R6 slot");
          endcase
        end
      end
    end

    // R8 requests while busy are ignored, at several points of the operation
    for (int p = 2; p < SLOT*CPU; p += 7)
      run_cmd(2'b01, 1'b0, SM_NONE, p, W0L*CPU, SLOT*CPU+1, 0, "R8 low", "R8 done");
    run_cmd(2'b00, 1'b0, SM_PRES, 100, RLEFF*CPU, (RLEFF+RHEFF)*CPU+1, 1, "R8 low", "R8 done");

    // R9 reserved opcode
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      cmd_op = 2'b11; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pull || busy || done) seen++;
      end
      check(seen == 0, "R9", seen, 0);
    end

    // R3 once more after the ignored opcode
    run_cmd(2'b00, 1'b0, SM_PRES, 0, RLEFF*CPU, (RLEFF+RHEFF)*CPU+1, 1, "R1 low", "R2 window");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule